// File: doc/BRIEF.md
# Port Register Block with Bit-Banged Sensor Clock

This block holds the software-visible state of two general-purpose I/O ports, here called port A and port D, behind a single-cycle word-addressed read/write bus. Each port has three words: an output-value word, an input-sample word and a drive-enable word. The output-value and drive-enable words of both ports are brought out as pins. Any other word inside the 23-word window is plain scratch storage.

Two ports read their pins. A read of port A's input word returns the driven bits (output value ANDed with drive enable), with a NAND flash ready line ORed in at bit 7. A read of port D's input word does the same, with the serial temperature sensor's data line ORed in at bit 4. Software talks to the sensor by bit-banging. Each write to port D's output word that flips bit 1 sends the sensor one clock edge. The new level of bit 1 is the edge direction, and bit 4 of the same write is the data bit handed to the sensor.

Top module: `gpio_sens_regs`

## Requirements
- R1: After synchronous reset, all 23 stored words, all four port pin buses, bus_rdata, bus_rvalid, sens_edge_o, sens_clk_o and sens_dat_o are zero.
- R2: A read request (bus_sel=1, bus_we=0) is answered in the next cycle. bus_rvalid is high for that one cycle and bus_rdata holds the data. A read of a word with no special function returns the last value written to it. This includes the output-value and drive-enable words, and scratch words such as 0x05 and 0x16.
- R3: A read of word 0x01 (port A input) returns (word 0x00 AND word 0x02), with nand_ready_i sampled at the request edge ORed into bit 7. A value written to word 0x01 does not change what this read returns.
- R4: A read of word 0x11 (port D input) returns (word 0x10 AND word 0x12), with sens_sdo_i sampled at the request edge ORed into bit 4.
- R5: A write to word 0x10 whose bit 1 differs from the stored bit 1 raises sens_edge_o for the cycle after the write. From that cycle onward, sens_clk_o equals the written bit 1 and sens_dat_o equals the written bit 4. Toggling writes in consecutive cycles give consecutive pulses.
- R6: A write to word 0x10 that leaves bit 1 unchanged stores the value without raising sens_edge_o. sens_clk_o and sens_dat_o keep their levels.
- R7: Word indices 0x17 and above lie outside the window. Reads there return zero with bus_rvalid high. Writes there change no stored word and no pin.
- R8: porta_dout_o, porta_oe_o, portd_dout_o and portd_oe_o always show the contents of words 0x00, 0x02, 0x10 and 0x12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid, one cycle after the request |
| nand_ready_i | input | 1 | NAND flash ready line |
| sens_sdo_i | input | 1 | Temperature sensor serial data output |
| sens_edge_o | output | 1 | One-cycle strobe: a sensor clock edge occurred |
| sens_clk_o | output | 1 | Sensor clock level |
| sens_dat_o | output | 1 | Data bit presented to the sensor |
| porta_dout_o | output | 32 | Port A output-value word |
| porta_oe_o | output | 32 | Port A drive-enable word |
| portd_dout_o | output | 32 | Port D output-value word |
| portd_oe_o | output | 32 | Port D drive-enable word |

## Verification
A clock-edge write to port D's output word can be followed directly by a read of port D's input word. The read request is on the bus in the same cycle the edge strobe is high. The bench provokes this with a write that flips bit 1 and, with no idle cycle between, a read of word 0x11, while it raises sens_sdo_i as the sensor would. It passes only if the strobe, clock level and data bit appear in that one cycle, and the read returns the freshly stored output word masked by enable with the new sensor bit at position 4.

// File: rtl/gpio_sens_pkg.sv
package gpio_sens_pkg;
  localparam int unsigned DEF_DW        = 32;
  localparam int unsigned DEF_WORDS     = 23;
  localparam int unsigned DEF_AW        = 6;
  // Word indices decoded by the read path and the sensor clock logic
  localparam int unsigned DEF_PA_OUT    = 0;
  localparam int unsigned DEF_PA_IN     = 1;
  localparam int unsigned DEF_PA_EN     = 2;
  localparam int unsigned DEF_PD_OUT    = 16;
  localparam int unsigned DEF_PD_IN     = 17;
  localparam int unsigned DEF_PD_EN     = 18;
  // Bit positions
  localparam int unsigned DEF_NAND_BIT  = 7;
  localparam int unsigned DEF_SDO_BIT   = 4;
  localparam int unsigned DEF_SCK_BIT   = 1;
  localparam int unsigned DEF_SDI_BIT   = 4;

  typedef enum logic [1:0] {
    RD_STORE = 2'd0,
    RD_PORTA = 2'd1,
    RD_PORTD = 2'd2,
    RD_ZERO  = 2'd3
  } rd_kind_e;
endpackage

// File: rtl/gpio_sens_regfile.sv
module gpio_sens_regfile #(
  parameter int unsigned DW     = 32,
  parameter int unsigned WORDS  = 23,
  parameter int unsigned PA_OUT = 0,
  parameter int unsigned PA_EN  = 2,
  parameter int unsigned PD_OUT = 16,
  parameter int unsigned PD_EN  = 18,
  localparam int unsigned IW    = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_word,
  output logic [DW-1:0] tap_pa_out,
  output logic [DW-1:0] tap_pa_en,
  output logic [DW-1:0] tap_pd_out,
  output logic [DW-1:0] tap_pd_en
);
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_data;
    end
  end

  // Caller only uses rd_word for indices inside the window
  always_comb begin
    rd_word = '0;
    for (int i = 0; i < WORDS; i++)
      if (rd_idx == IW'(i)) rd_word = mem[i];
  end

  assign tap_pa_out = mem[PA_OUT];
  assign tap_pa_en  = mem[PA_EN];
  assign tap_pd_out = mem[PD_OUT];
  assign tap_pd_en  = mem[PD_EN];
endmodule

// File: rtl/gpio_sens_sck.sv
module gpio_sens_sck (
  input  logic clk,
  input  logic rst,
  input  logic wr_hit,
  input  logic old_sck,
  input  logic new_sck,
  input  logic new_sdi,
  output logic edge_o,
  output logic sck_o,
  output logic sdi_o
);
  logic flip;
  assign flip = wr_hit && (old_sck != new_sck);

  always_ff @(posedge clk) begin
    if (rst) begin
      edge_o <= 1'b0;
      sck_o  <= 1'b0;
      sdi_o  <= 1'b0;
    end else begin
      edge_o <= flip;
      if (flip) begin
        sck_o <= new_sck;
        sdi_o <= new_sdi;
      end
    end
  end
endmodule

// File: rtl/gpio_sens_rdport.sv
module gpio_sens_rdport
  import gpio_sens_pkg::*;
#(
  parameter int unsigned DW       = 32,
  parameter int unsigned NAND_BIT = 7,
  parameter int unsigned SDO_BIT  = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  rd_kind_e      kind,
  input  logic [DW-1:0] store_word,
  input  logic [DW-1:0] pa_out,
  input  logic [DW-1:0] pa_en,
  input  logic [DW-1:0] pd_out,
  input  logic [DW-1:0] pd_en,
  input  logic          nand_rdy,
  input  logic          sdo,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);
  logic [DW-1:0] pin_a, pin_d, nxt;

  always_comb begin
    pin_a = '0;
    pin_a[NAND_BIT] = nand_rdy;
    pin_d = '0;
    pin_d[SDO_BIT] = sdo;
    unique case (kind)
      RD_STORE: nxt = store_word;
      RD_PORTA: nxt = (pa_out & pa_en) | pin_a;
      RD_PORTD: nxt = (pd_out & pd_en) | pin_d;
      default:  nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= nxt;
    end
  end
endmodule

// File: rtl/gpio_sens_regs.sv
module gpio_sens_regs
  import gpio_sens_pkg::*;
#(
  parameter int unsigned DW       = DEF_DW,
  parameter int unsigned WORDS    = DEF_WORDS,
  parameter int unsigned AW       = DEF_AW,
  parameter int unsigned PA_OUT   = DEF_PA_OUT,
  parameter int unsigned PA_IN    = DEF_PA_IN,
  parameter int unsigned PA_EN    = DEF_PA_EN,
  parameter int unsigned PD_OUT   = DEF_PD_OUT,
  parameter int unsigned PD_IN    = DEF_PD_IN,
  parameter int unsigned PD_EN    = DEF_PD_EN,
  parameter int unsigned NAND_BIT = DEF_NAND_BIT,
  parameter int unsigned SDO_BIT  = DEF_SDO_BIT,
  parameter int unsigned SCK_BIT  = DEF_SCK_BIT,
  parameter int unsigned SDI_BIT  = DEF_SDI_BIT
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_rvalid,
  input  logic          nand_ready_i,
  input  logic          sens_sdo_i,
  output logic          sens_edge_o,
  output logic          sens_clk_o,
  output logic          sens_dat_o,
  output logic [DW-1:0] porta_dout_o,
  output logic [DW-1:0] porta_oe_o,
  output logic [DW-1:0] portd_dout_o,
  output logic [DW-1:0] portd_oe_o
);
  localparam int unsigned IW = $clog2(WORDS);
  localparam logic [AW-1:0] LIMIT   = AW'(WORDS);
  localparam logic [AW-1:0] A_PA_IN = AW'(PA_IN);
  localparam logic [AW-1:0] A_PD_IN = AW'(PD_IN);
  localparam logic [AW-1:0] A_PD_OUT = AW'(PD_OUT);

  logic          in_win, wr_en, rd_en, pd_hit;
  logic [IW-1:0] idx;
  logic [DW-1:0] store_word;
  rd_kind_e      kind;

  assign in_win = bus_addr < LIMIT;
  assign idx    = bus_addr[IW-1:0];
  assign wr_en  = bus_sel && bus_we && in_win;
  assign rd_en  = bus_sel && !bus_we;
  assign pd_hit = bus_sel && bus_we && (bus_addr == A_PD_OUT);

  always_comb begin
    if (!in_win)                kind = RD_ZERO;
    else if (bus_addr == A_PA_IN) kind = RD_PORTA;
    else if (bus_addr == A_PD_IN) kind = RD_PORTD;
    else                        kind = RD_STORE;
  end

  gpio_sens_regfile #(
    .DW(DW), .WORDS(WORDS),
    .PA_OUT(PA_OUT), .PA_EN(PA_EN), .PD_OUT(PD_OUT), .PD_EN(PD_EN)
  ) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_idx     (idx),
    .wr_data    (bus_wdata),
    .rd_idx     (idx),
    .rd_word    (store_word),
    .tap_pa_out (porta_dout_o),
    .tap_pa_en  (porta_oe_o),
    .tap_pd_out (portd_dout_o),
    .tap_pd_en  (portd_oe_o)
  );

  gpio_sens_sck u_sck (
    .clk     (clk),
    .rst     (rst),
    .wr_hit  (pd_hit),
    .old_sck (portd_dout_o[SCK_BIT]),
    .new_sck (bus_wdata[SCK_BIT]),
    .new_sdi (bus_wdata[SDI_BIT]),
    .edge_o  (sens_edge_o),
    .sck_o   (sens_clk_o),
    .sdi_o   (sens_dat_o)
  );

  gpio_sens_rdport #(
    .DW(DW), .NAND_BIT(NAND_BIT), .SDO_BIT(SDO_BIT)
  ) u_rd (
    .clk        (clk),
    .rst        (rst),
    .rd_en      (rd_en),
    .kind       (kind),
    .store_word (store_word),
    .pa_out     (porta_dout_o),
    .pa_en      (porta_oe_o),
    .pd_out     (portd_dout_o),
    .pd_en      (portd_oe_o),
    .nand_rdy   (nand_ready_i),
    .sdo        (sens_sdo_i),
    .rdata      (bus_rdata),
    .rvalid     (bus_rvalid)
  );
endmodule

// File: rtl/gpio_sens_regs_chk.sv
module gpio_sens_regs_chk
  import gpio_sens_pkg::*;
#(
  parameter int unsigned DW       = DEF_DW,
  parameter int unsigned WORDS    = DEF_WORDS,
  parameter int unsigned AW       = DEF_AW,
  parameter int unsigned PA_IN    = DEF_PA_IN,
  parameter int unsigned PD_OUT   = DEF_PD_OUT,
  parameter int unsigned NAND_BIT = DEF_NAND_BIT,
  parameter int unsigned SCK_BIT  = DEF_SCK_BIT
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_sel,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_rdata,
  input logic          bus_rvalid,
  input logic          nand_ready_i,
  input logic          sens_edge_o,
  input logic          sens_clk_o,
  input logic          sens_dat_o,
  input logic [DW-1:0] portd_dout_o
);
  localparam logic [AW-1:0] LIMIT   = AW'(WORDS);
  localparam logic [AW-1:0] A_PA_IN = AW'(PA_IN);
  localparam logic [AW-1:0] A_PD_OUT = AW'(PD_OUT);

  assert_read_answer_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_we) |=> bus_rvalid);

  assert_rvalid_cause_R2: assert property (@(posedge clk) disable iff (rst)
    bus_rvalid |-> $past(bus_sel && !bus_we));

  assert_nand_bit_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_rvalid && $past(bus_addr == A_PA_IN && nand_ready_i)) |-> bus_rdata[NAND_BIT]);

  assert_edge_cause_R5: assert property (@(posedge clk) disable iff (rst)
    sens_edge_o |-> $past(bus_sel && bus_we && bus_addr == A_PD_OUT));

  assert_edge_level_R5: assert property (@(posedge clk) disable iff (rst)
    sens_edge_o |-> (sens_clk_o == portd_dout_o[SCK_BIT]));

  assert_hold_levels_R6: assert property (@(posedge clk) disable iff (rst)
    !sens_edge_o |-> ($stable(sens_clk_o) && $stable(sens_dat_o)));

  assert_outside_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_rvalid && $past(bus_addr >= LIMIT)) |-> (bus_rdata == '0));
endmodule

bind gpio_sens_regs gpio_sens_regs_chk u_chk (.*);

// File: tb/gpio_sens_regs_test.sv
module gpio_sens_regs_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        nand_ready_i = 1'b0;
  logic        sens_sdo_i = 1'b0;
  logic        sens_edge_o, sens_clk_o, sens_dat_o;
  logic [31:0] porta_dout_o, porta_oe_o, portd_dout_o, portd_oe_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  gpio_sens_regs uut (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Tasks start and end at a falling edge
  task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [5:0] a, output logic [31:0] d, output logic v);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(posedge clk); @(negedge clk);
    d = bus_rdata; v = bus_rvalid;
    bus_sel = 1'b0;
  endtask

  task automatic read_expect(input logic [5:0] a, input logic [31:0] exp, input string req);
    logic [31:0] d; logic v;
    bus_read(a, d, v);
    check(v, {req, " rvalid"}, {31'd0, v}, 32'd1);
    check(d === exp, req, d, exp);
  endtask

  task automatic t_reset;
    check(bus_rdata === 0 && !bus_rvalid, "R1 read port", bus_rdata, 0);
    check({sens_edge_o, sens_clk_o, sens_dat_o} === 3'b000, "R1 sensor pins",
          {29'd0, sens_edge_o, sens_clk_o, sens_dat_o}, 0);
    check((porta_dout_o | porta_oe_o | portd_dout_o | portd_oe_o) === 0, "R1 port pins",
          porta_dout_o | porta_oe_o | portd_dout_o | portd_oe_o, 0);
    read_expect(6'h05, 32'h0, "R1 scratch word");
  endtask

  task automatic t_storage;
    bus_write(6'h00, 32'hA5A5_0034);
    check(porta_dout_o === 32'hA5A5_0034, "R8 porta_dout_o", porta_dout_o, 32'hA5A5_0034);
    bus_write(6'h02, 32'h0000_FF0F);
    check(porta_oe_o === 32'h0000_FF0F, "R8 porta_oe_o", porta_oe_o, 32'h0000_FF0F);
    bus_write(6'h05, 32'h1234_5678);
    bus_write(6'h16, 32'hDEAD_BEEF);
    read_expect(6'h00, 32'hA5A5_0034, "R2 port A out word");
    read_expect(6'h02, 32'h0000_FF0F, "R2 port A enable word");
    read_expect(6'h05, 32'h1234_5678, "R2 scratch 0x05");
    read_expect(6'h16, 32'hDEAD_BEEF, "R2 last word 0x16");
  endtask

  task automatic t_porta_in;
    nand_ready_i = 1'b0;
    read_expect(6'h01, 32'h0000_0004, "R3 nand low");
    nand_ready_i = 1'b1;
    read_expect(6'h01, 32'h0000_0084, "R3 nand high");
    bus_write(6'h01, 32'hFFFF_FFFF);
    read_expect(6'h01, 32'h0000_0084, "R3 stored input word ignored");
    nand_ready_i = 1'b0;
  endtask

  task automatic t_portd_in;
    bus_write(6'h12, 32'h0000_00FF);
    check(portd_oe_o === 32'h0000_00FF, "R8 portd_oe_o", portd_oe_o, 32'h0000_00FF);
    bus_write(6'h10, 32'h0000_0041);
    check(!sens_edge_o, "R6 no edge bit1 stays 0", {31'd0, sens_edge_o}, 0);
    check(portd_dout_o === 32'h0000_0041, "R8 portd_dout_o", portd_dout_o, 32'h0000_0041);
    sens_sdo_i = 1'b0;
    read_expect(6'h11, 32'h0000_0041, "R4 sdo low");
    sens_sdo_i = 1'b1;
    read_expect(6'h11, 32'h0000_0051, "R4 sdo high");
    sens_sdo_i = 1'b0;
  endtask

  task automatic t_clock_edges;
    bus_write(6'h10, 32'h0000_0053);
    check({sens_edge_o, sens_clk_o, sens_dat_o} === 3'b111, "R5 rising edge with data 1",
          {29'd0, sens_edge_o, sens_clk_o, sens_dat_o}, 32'd7);
    @(negedge clk);
    check({sens_edge_o, sens_clk_o, sens_dat_o} === 3'b011, "R5 pulse one cycle",
          {29'd0, sens_edge_o, sens_clk_o, sens_dat_o}, 32'd3);
    bus_write(6'h10, 32'h0000_0041);
    check({sens_edge_o, sens_clk_o, sens_dat_o} === 3'b100, "R5 falling edge with data 0",
          {29'd0, sens_edge_o, sens_clk_o, sens_dat_o}, 32'd4);
    bus_write(6'h10, 32'h0000_0050);
    check({sens_edge_o, sens_clk_o, sens_dat_o} === 3'b000, "R6 data change without clock",
          {29'd0, sens_edge_o, sens_clk_o, sens_dat_o}, 32'd0);
    read_expect(6'h10, 32'h0000_0050, "R6 value stored");
    // back-to-back toggles
    bus_write(6'h10, 32'h0000_0052);
    check({sens_edge_o, sens_clk_o, sens_dat_o} === 3'b111, "R5 first of two",
          {29'd0, sens_edge_o, sens_clk_o, sens_dat_o}, 32'd7);
    bus_write(6'h10, 32'h0000_0040);
    check({sens_edge_o, sens_clk_o, sens_dat_o} === 3'b100, "R5 second of two",
          {29'd0, sens_edge_o, sens_clk_o, sens_dat_o}, 32'd4);
  endtask

  task automatic t_edge_then_read;
    logic [31:0] d; logic v;
    bus_write(6'h10, 32'h0000_0042);
    check({sens_edge_o, sens_clk_o, sens_dat_o} === 3'b110, "R5 edge beside read",
          {29'd0, sens_edge_o, sens_clk_o, sens_dat_o}, 32'd6);
    sens_sdo_i = 1'b1;
    bus_read(6'h11, d, v);
    check(v && d === 32'h0000_0052, "R4 read after edge", d, 32'h0000_0052);
    check(!sens_edge_o, "R5 strobe ended", {31'd0, sens_edge_o}, 0);
    sens_sdo_i = 1'b0;
  endtask

  task automatic t_outside;
    read_expect(6'h17, 32'h0, "R7 first outside word");
    read_expect(6'h3F, 32'h0, "R7 top index");
    bus_write(6'h20, 32'hFFFF_FFFF);
    bus_write(6'h17, 32'hFFFF_FFFF);
    check(porta_dout_o === 32'hA5A5_0034 && portd_oe_o === 32'h0000_00FF,
          "R7 pins after outside write", porta_dout_o, 32'hA5A5_0034);
    read_expect(6'h00, 32'hA5A5_0034, "R7 word 0 intact");
    read_expect(6'h16, 32'hDEAD_BEEF, "R7 word 0x16 intact");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_storage;
    t_porta_in;
    t_portd_in;
    t_clock_edges;
    t_edge_then_read;
    t_outside;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule